// File: doc/BRIEF.md
# Segmented Byte-Code Processor Core

This block is a small multicycle processor that runs a compact eight-instruction byte code out of its own 4096-byte memory. It has six 8-bit registers, an 8-bit flag byte and an 8-bit instruction pointer. Code and data are reached through segments. A physical address is the segment value times 16 plus an 8-bit offset, taken modulo 4096. Register 4 supplies the code segment and register 5 supplies the data segment.

A host fills memory through a write port while the core is stopped. It then pulses `start` and waits for `halted` to rise again. After the halt it reads results back through a read port, and it can watch the register state on the debug outputs. Each instruction passes through a first fetch. Two-byte instructions add a second fetch. Every instruction except halt then spends one execute cycle, and memory moves spend one more cycle in a memory-access state.

Top module: `seg8_core`

## Requirements
- R1: After reset, `halted` is 1 and the instruction pointer, the flag byte and all six registers are 0.
- R2: The first instruction byte carries the opcode in bits 7..5, a mode bit in bit 4 and the first register index in bits 3..0. Opcode 1 copies the second operand into the first register. Opcode 3 adds the second operand modulo 256. Opcode 4 XORs it. With mode 0 the second operand is the register named by bits 3..0 of the second byte. With mode 1 it is the whole second byte.
- R3: Opcode 5 compares the first register with the second operand as unsigned values. It sets the flag byte to 0x00 when they are equal, to 0xFF when the register is smaller and to 0x01 when it is larger.
- R4: Opcode 2 with mode 0 loads register[op1] from address DS*16 + register[op2 index]. With mode 1 it stores register[op2 index] to address DS*16 + register[op1]. In both cases the address wraps modulo 4096.
- R5: Opcode 0 with mode 0 is one byte long and loads the instruction pointer from register[op1].
- R6: Opcode 0 with mode 1 is two bytes long. It loads the instruction pointer from register[op1] and the code segment (register 4) from the second byte, both taken from values held before the instruction.
- R7: Opcode 6 behaves like opcode 0 in the same mode when the flag byte is 0. Otherwise it only moves the instruction pointer past itself by 1 byte in mode 0 or 2 bytes in mode 1.
- R8: Opcode 7 stops the core with `halted` high and the instruction pointer still on the halt byte. Registers and IP stay unchanged while the core is halted, and a new start fetches the same halt again.
- R9: Instruction bytes are fetched from CS*16 + IP. The instruction pointer advances modulo 256.
- R10: Register indices 6 to 15 read as zero, and writes to them change no register.
- R11: The host write port and `start` act only while `halted` is high. While the core runs, `host_rdata` reads 0 and host writes leave memory unchanged.
- R12: One-byte jumps take 2 cycles. Other two-byte instructions take 3 cycles, and memory moves take 4. `halted` rises 2 cycles plus the sum of the executed instructions' cycles after the clock edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of core state (memory keeps its contents) |
| start | input | 1 | Begin execution from the current IP and code segment |
| halted | output | 1 | High while the core is not running |
| host_we | input | 1 | Host memory write strobe |
| host_addr | input | 12 | Host memory address for both reads and writes |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Memory byte at `host_addr` while halted, 0 while running |
| dbg_ip | output | 8 | Instruction pointer |
| dbg_fl | output | 8 | Flag byte |
| dbg_regs | output | 48 | Registers 0..5, register n in bits 8n+7..8n |

## Verification
Every register result lands on the clock edge that ends the instruction's execute cycle, or its memory-access cycle for a loading memory move. Memory reads show up on `host_rdata` in the same cycle the address is driven. The bench therefore waits for `halted` and then samples all results at a falling edge. It counts the rising edges from the sampled `start` to `halted`, and it compares that count with the cycle sum in R12 worked out for each program. Samples taken while the core runs also fall between edges, a few cycles after `start`, when the core is known to be looping.

// File: rtl/seg8_core.sv
module seg8_core #(
  parameter int ADDR_W    = 12,
  parameter int SEG_SHIFT = 4,
  parameter int NREG      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              halted,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic [7:0]        dbg_ip,
  output logic [7:0]        dbg_fl,
  output logic [8*NREG-1:0] dbg_regs
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int RI_W   = $clog2(NREG);
  localparam int CS_IDX = 4;
  localparam int DS_IDX = 5;

  typedef enum logic [2:0] {ST_IDLE, ST_F1, ST_F2, ST_EX, ST_MEM, ST_HALT} st_t;
  typedef enum logic [2:0] {OP_JMP, OP_MOVR, OP_MOVM, OP_ADD, OP_XOR, OP_CMP, OP_JMPE, OP_HLT} op_t;

  st_t               state;
  logic [7:0]        mem [DEPTH];
  logic [7:0]        rf  [NREG];
  logic [7:0]        ip, fl, ir, op2;
  logic [ADDR_W-1:0] maddr;
  logic [7:0]        mdata;

  function automatic logic [ADDR_W-1:0] pa(input logic [7:0] seg, input logic [7:0] off);
    logic [ADDR_W+8:0] s;
    s = ({{(ADDR_W+1){1'b0}}, seg} << SEG_SHIFT) + {{(ADDR_W+1){1'b0}}, off};
    return s[ADDR_W-1:0];
  endfunction

  function automatic logic [7:0] rd(input logic [3:0] idx);
    return (idx < 4'(NREG)) ? rf[idx[RI_W-1:0]] : 8'h00;
  endfunction

  wire op_t        opc   = op_t'(ir[7:5]);
  wire             md    = ir[4];
  wire [3:0]       ra    = ir[3:0];
  wire [7:0]       cs    = rf[CS_IDX];
  wire [7:0]       ds    = rf[DS_IDX];
  wire [7:0]       a_val = rd(ra);
  wire [7:0]       b_reg = rd(op2[3:0]);
  wire [7:0]       b_val = md ? op2 : b_reg;
  wire [7:0]       fb    = mem[pa(cs, ip)];
  wire [7:0]       sb    = mem[pa(cs, ip + 8'd1)];
  wire op_t        f_opc = op_t'(fb[7:5]);
  wire             f_one = (f_opc == OP_JMP || f_opc == OP_JMPE) && !fb[4];
  wire             take  = (opc == OP_JMP) || (opc == OP_JMPE && fl == 8'h00);

  assign halted     = (state == ST_IDLE) || (state == ST_HALT);
  assign host_rdata = halted ? mem[host_addr] : 8'h00;
  assign dbg_ip     = ip;
  assign dbg_fl     = fl;

  for (genvar i = 0; i < NREG; i++) begin : g_dbg
    assign dbg_regs[8*i +: 8] = rf[i];
  end

  logic       rf_we;
  logic [3:0] rf_wi;
  logic [7:0] rf_wd;

  always_comb begin
    rf_we = 1'b0;
    rf_wi = ra;
    rf_wd = 8'h00;
    if (state == ST_EX) begin
      case (opc)
        OP_MOVR: begin rf_we = 1'b1; rf_wd = b_val; end
        OP_ADD:  begin rf_we = 1'b1; rf_wd = a_val + b_val; end
        OP_XOR:  begin rf_we = 1'b1; rf_wd = a_val ^ b_val; end
        OP_JMP, OP_JMPE: begin
          rf_we = take && md;
          rf_wi = 4'(CS_IDX);
          rf_wd = op2;
        end
        default: ;
      endcase
    end else if (state == ST_MEM && !md) begin
      rf_we = 1'b1;
      rf_wd = mem[maddr];
    end
  end

  always_ff @(posedge clk) begin
    if (host_we && halted)
      mem[host_addr] <= host_wdata;
    else if (state == ST_MEM && md)
      mem[maddr] <= mdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= 8'h00;
    end else if (rf_we && rf_wi < 4'(NREG)) begin
      rf[rf_wi[RI_W-1:0]] <= rf_wd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ip    <= 8'h00;
      fl    <= 8'h00;
      ir    <= 8'h00;
      op2   <= 8'h00;
      maddr <= '0;
      mdata <= 8'h00;
    end else begin
      case (state)
        ST_IDLE, ST_HALT: if (start) state <= ST_F1;
        ST_F1: begin
          ir <= fb;
          if (f_opc == OP_HLT) state <= ST_HALT;
          else if (f_one) begin
            ip    <= ip + 8'd1;
            state <= ST_EX;
          end else state <= ST_F2;
        end
        ST_F2: begin
          op2   <= sb;
          ip    <= ip + 8'd2;
          state <= ST_EX;
        end
        ST_EX: begin
          state <= ST_F1;
          case (opc)
            OP_JMP, OP_JMPE: if (take) ip <= a_val;
            OP_CMP: fl <= (a_val == b_val) ? 8'h00 : (a_val < b_val) ? 8'hFF : 8'h01;
            OP_MOVM: begin
              maddr <= md ? pa(ds, a_val) : pa(ds, b_reg);
              mdata <= b_reg;
              state <= ST_MEM;
            end
            default: ;
          endcase
        end
        ST_MEM:  state <= ST_F1;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg8_core_chk.sv
module seg8_core_chk #(
  parameter int ADDR_W = 12,
  parameter int NREG   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              halted,
  input logic [7:0]        dbg_ip,
  input logic [7:0]        dbg_fl,
  input logic [8*NREG-1:0] dbg_regs,
  input logic [7:0]        host_rdata
);
  a_r3_flag_values: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_fl == 8'h00) || (dbg_fl == 8'h01) || (dbg_fl == 8'hFF));

  a_r8_ip_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && $past(halted)) |-> $stable(dbg_ip));

  a_r8_regs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && $past(halted)) |-> ($stable(dbg_regs) && $stable(dbg_fl)));

  a_r11_read_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |-> (host_rdata == 8'h00));
endmodule

bind seg8_core seg8_core_chk #(.ADDR_W(ADDR_W), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .halted(halted), .dbg_ip(dbg_ip),
  .dbg_fl(dbg_fl), .dbg_regs(dbg_regs), .host_rdata(host_rdata)
);

// File: tb/seg8_core_test.sv
`timescale 1ns/1ps
module seg8_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        halted;
  logic        host_we = 1'b0;
  logic [11:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata, dbg_ip, dbg_fl;
  logic [47:0] dbg_regs;
  int total = 0, fails = 0;

  always #5 clk = ~clk;

  seg8_core uut (
    .clk(clk), .rst_n(rst_n), .start(start), .halted(halted),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .dbg_ip(dbg_ip), .dbg_fl(dbg_fl), .dbg_regs(dbg_regs)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] r(input int i);
    return dbg_regs[8*i +: 8];
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic put(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic peek(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; #1 d = host_rdata;
  endtask

  task automatic run(output int n);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; n = 1;
    while (!halted && n < 2000) begin @(negedge clk); n++; end
  endtask

  function automatic logic [7:0] cmpv(input logic [7:0] a, input logic [7:0] b);
    return (a == b) ? 8'h00 : (a < b) ? 8'hFF : 8'h01;
  endfunction

  initial begin
    #2000000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] vals [8] = '{8'h00, 8'h01, 8'h0F, 8'h7F, 8'h80, 8'hA5, 8'hFE, 8'hFF};
    logic [7:0] d;
    int n;

    do_reset();
    // R1 reset state
    chk("R1 halted", halted, 1);
    chk("R1 ip", dbg_ip, 0);
    chk("R1 fl", dbg_fl, 0);
    chk("R1 regs", dbg_regs, 0);

    // R2/R3/R12 sweep of ALU ops, R8 halt restart
    foreach (vals[i]) foreach (vals[j]) begin
      logic [7:0] a, b, s, x;
      a = vals[i]; b = vals[j]; s = a + b; x = a ^ b;
      do_reset();
      put(0, 8'h30); put(1, a); put(2, 8'h70); put(3, b);
      put(4, 8'h31); put(5, a); put(6, 8'h91); put(7, b);
      put(8, 8'h32); put(9, a); put(10, 8'hB2); put(11, b);
      put(12, 8'h23); put(13, 8'h00); put(14, 8'h63); put(15, 8'h01);
      put(16, 8'hE0); put(17, 8'h00);
      run(n);
      chk("R12 alu cycles", n, 26);
      chk("R2 add", r(0), s);
      chk("R2 xor", r(1), x);
      chk("R2 reg mode add", r(3), 8'(s + x));
      chk("R3 cmp", dbg_fl, cmpv(a, b));
      chk("R8 ip on halt", dbg_ip, 16);
      if (i == 3 && j == 5) begin
        repeat (4) @(negedge clk);
        run(n);
        chk("R8 restart cycles", n, 2);
        chk("R8 restart ip", dbg_ip, 16);
        chk("R8 restart reg", r(3), 8'(s + x));
      end
    end

    // R4 memory moves with segment wrap
    for (int k = 0; k < 5; k++) begin
      logic [7:0] sg, of, dt;
      logic [11:0] ea;
      sg = (k == 0) ? 8'h20 : (k == 1) ? 8'h40 : (k == 2) ? 8'h7F : (k == 3) ? 8'hFF : 8'hF0;
      of = (k == 0) ? 8'h07 : (k == 1) ? 8'h80 : (k == 2) ? 8'hFF : (k == 3) ? 8'hFF : 8'h30;
      dt = of ^ 8'hA5 ^ 8'(k);
      ea = 12'((int'(sg) * 16 + int'(of)) % 4096);
      do_reset();
      put(0, 8'h35); put(1, sg); put(2, 8'h30); put(3, of);
      put(4, 8'h31); put(5, dt); put(6, 8'h50); put(7, 8'h01);
      put(8, 8'h42); put(9, 8'h00); put(10, 8'hE0); put(11, 8'h00);
      run(n);
      chk("R12 movm cycles", n, 19);
      peek(ea, d);
      chk("R4 store", d, dt);
      chk("R4 load", r(2), dt);
      chk("R4 ip", dbg_ip, 10);
    end

    // R5 near jump
    do_reset();
    put(0, 8'h30); put(1, 8'h08); put(2, 8'h00); put(3, 8'h31); put(4, 8'hEE);
    put(5, 8'hE0); put(6, 8'h00); put(8, 8'hE0); put(9, 8'h00);
    run(n);
    chk("R12 jmp cycles", n, 7);
    chk("R5 ip", dbg_ip, 8);
    chk("R5 skipped", r(1), 0);

    // R6 far jump
    do_reset();
    put(0, 8'h30); put(1, 8'h03); put(2, 8'h10); put(3, 8'h05);
    put(12'h53, 8'h31); put(12'h54, 8'h77); put(12'h55, 8'hE0); put(12'h56, 8'h00);
    run(n);
    chk("R6 cs", r(4), 5);
    chk("R6 ip", dbg_ip, 5);
    chk("R6 target ran", r(1), 8'h77);

    // R7 conditional jump
    foreach (vals[i]) foreach (vals[j]) if (i % 2 == 0 && j % 2 == 0 || i == j) begin
      do_reset();
      put(0, 8'h30); put(1, vals[i]); put(2, 8'hB0); put(3, vals[j]);
      put(4, 8'h32); put(5, 8'h0A); put(6, 8'hC2); put(7, 8'h31); put(8, 8'h11);
      put(9, 8'hE0); put(10, 8'hE0); put(11, 8'h00);
      run(n);
      chk("R7 ip", dbg_ip, (vals[i] == vals[j]) ? 10 : 9);
      chk("R7 fallthrough", r(1), (vals[i] == vals[j]) ? 0 : 8'h11);
    end

    // R9 IP wrap within segment 1
    do_reset();
    put(0, 8'h30); put(1, 8'hFE); put(2, 8'h10); put(3, 8'h01);
    put(12'h10E, 8'h31); put(12'h10F, 8'h44); put(12'h10, 8'hE0); put(12'h11, 8'h00);
    run(n);
    chk("R9 ip wrapped", dbg_ip, 0);
    chk("R9 wrapped fetch", r(1), 8'h44);
    chk("R9 cs", r(4), 1);

    // R10 out-of-range register indices
    do_reset();
    put(0, 8'h30); put(1, 8'h33); put(2, 8'h37); put(3, 8'h55);
    put(4, 8'h20); put(5, 8'h09); put(6, 8'h3C); put(7, 8'h66);
    put(8, 8'h39); put(9, 8'h5A); put(10, 8'hE0); put(11, 8'h00);
    run(n);
    chk("R10 read zero", r(0), 0);
    chk("R10 regs intact", dbg_regs, 0);
    chk("R10 ip", dbg_ip, 10);

    // R11 host port while running
    do_reset();
    put(12'h300, 8'h12); put(0, 8'h00);
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 running", halted, 0);
    host_addr = 12'h300; #1;
    chk("R11 read blank", host_rdata, 0);
    @(negedge clk); host_we = 1'b1; host_addr = 12'h300; host_wdata = 8'hAB;
    @(negedge clk); host_we = 1'b0;
    do_reset();
    peek(12'h300, d);
    chk("R11 write ignored", d, 8'h12);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule